// File: doc/BRIEF.md
# UART Receive Holding Queue

This block is the small holding queue between a UART receive deserializer and the register read port. Received bytes go in at the tail when the receiver is enabled and the queue has room. The oldest byte is always visible on the read data output, and a read strobe removes it. Two status flags come out of it: one saying that at least one byte is waiting and one saying that the queue is full. It also drives an accept signal back to the deserializer.

A line-break condition is handled as a special push. A break event always stores a zero byte and raises a sticky break-change interrupt flag. A break that arrives while the queue is full replaces the newest stored byte, so the break is not lost. A receiver-reset input empties the queue in one cycle. A separate clear input drops the break-change flag.

Control is a three-state machine on an occupancy count. The states are EMPTY, PARTIAL and FULL. The transitions are:
- fill (EMPTY to PARTIAL, or to FULL when the depth is 1)
- top-up (PARTIAL to FULL)
- drain (FULL to PARTIAL)
- last-read (PARTIAL or FULL to EMPTY)
- break-overwrite (FULL to FULL)
- flush (any state to EMPTY on receiver reset)

Top module: `rx_hold_queue`

## Requirements
- R1: The queue holds at most DEPTH (default 4) bytes. `full` is 1 exactly when DEPTH bytes are stored, and `full` implies `ready`.
- R2: `ready` is 1 exactly when at least one byte is stored. Any accepted push or break sets it on the next clock edge.
- R3: `accept` equals `rx_en AND NOT full AND NOT brk_evt`. A `push_valid` in a cycle where `accept` is 0 stores nothing.
- R4: A break event (`brk_evt`=1) sets `brk_flag` on the next edge and enqueues the byte 0x00. This happens whether or not `rx_en` is set.
- R5: A break event while the queue is full, with no read in the same cycle, overwrites the newest entry with 0x00. The count stays at DEPTH.
- R6: `rd_data` shows the oldest stored byte. A `rd_stb` removes it, and bytes leave in arrival order. A read of a full queue clears `full` unless a break refills it in the same cycle.
- R7: A `rd_stb` on an empty queue changes nothing. `rd_data` keeps the last head value, and the flags stay as they were.
- R8: When a read and a push occur in the same cycle, the read is applied first, so a full queue accepts a break into the freed slot and no byte is lost.
- R9: `rx_reset` empties the queue on the next edge and clears `ready` and `full`. It takes priority over a read or push in the same cycle, and it leaves `brk_flag` unchanged.
- R10: `brk_clr` clears `brk_flag`. If `brk_evt` and `brk_clr` are both 1 in the same cycle, the flag stays set.
- R11: After `rst_n` is released, `ready`, `full` and `brk_flag` are 0 and `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enabled |
| push_valid | input | 1 | Deserializer offers a byte |
| push_data | input | DATA_W | Offered byte |
| brk_evt | input | 1 | Line break detected |
| rd_stb | input | 1 | Register read removes the head byte |
| rx_reset | input | 1 | Receiver-reset command, empties queue |
| brk_clr | input | 1 | Clears the break-change flag |
| accept | output | 1 | Queue takes the offered byte this cycle |
| rd_data | output | DATA_W | Oldest stored byte |
| ready | output | 1 | At least one byte stored |
| full | output | 1 | DEPTH bytes stored |
| brk_flag | output | 1 | Sticky break-change interrupt flag |

## Verification
The assertions check these rules on every cycle:
- `full` implies `ready`.
- A cycle with no accepted push, break, read or reset leaves the flags and head byte stable.
- A break always sets the flag and makes data available.
- A break into a full queue keeps it full.
- An empty-queue read leaves the head byte alone.
- A reset command clears both flags.

Byte order, the exact value of each byte, the zero byte stored by a break, the overwrite position and the read-before-push ordering depend on the queue contents. Only the bench's scenarios show these. It sweeps every input combination from every fill level against an arithmetic model of the queue.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_PART  = 2'd1,
        Q_FULL  = 2'd2
    } q_state_e;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] head
);
    logic [DATA_W-1:0] slot_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [DATA_W-1:0] slot_d;
        always_comb begin
            slot_d = slot_q[i];
            if (wr_en && wr_idx == IDX_W'(i)) begin
                slot_d = wr_data;
            end else if (shift_en) begin
                if (i < DEPTH - 1) slot_d = slot_q[(i < DEPTH - 1) ? i + 1 : i];
            end
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q[i] <= '0;
            else        slot_q[i] <= slot_d;
        end
    end

    assign head = slot_q[0];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
    parameter int DEPTH  = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             push_valid,
    input  logic             brk_evt,
    input  logic             rd_stb,
    input  logic             rx_reset,
    input  logic             brk_clr,
    output logic             accept,
    output logic             ready,
    output logic             full,
    output logic             brk_flag,
    output logic             shift_en,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx
);
    import rxq_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    q_state_e         state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_rd;
    logic             do_rd, do_push, full_after_rd, brk_q;

    // Datapath decisions: read is applied before push.
    always_comb begin
        do_rd         = rd_stb && (state_q != Q_EMPTY);
        cnt_rd        = do_rd ? cnt_q - CNT_W'(1) : cnt_q;
        do_push       = brk_evt || (push_valid && accept);
        full_after_rd = (cnt_rd == CNT_MAX);
        wr_idx        = full_after_rd ? IDX_W'(DEPTH - 1) : cnt_rd[IDX_W-1:0];
        wr_en         = do_push && !rx_reset;
        shift_en      = do_rd && (cnt_q > CNT_W'(1)) && !rx_reset;
        if (rx_reset)
            cnt_d = '0;
        else if (do_push && !full_after_rd)
            cnt_d = cnt_rd + CNT_W'(1);
        else
            cnt_d = cnt_rd;
    end

    // Next-state logic with named transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Q_EMPTY: begin
                if (!rx_reset && do_push)                // fill
                    state_d = (cnt_d == CNT_MAX) ? Q_FULL : Q_PART;
            end
            Q_PART: begin
                if (rx_reset || cnt_d == '0)             // flush / last-read
                    state_d = Q_EMPTY;
                else if (cnt_d == CNT_MAX)               // top-up
                    state_d = Q_FULL;
            end
            Q_FULL: begin
                if (rx_reset || cnt_d == '0)             // flush / last-read
                    state_d = Q_EMPTY;
                else if (cnt_d != CNT_MAX)               // drain
                    state_d = Q_PART;
                // otherwise break-overwrite keeps FULL
            end
            default: state_d = Q_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= Q_EMPTY;
            cnt_q   <= '0;
            brk_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (brk_evt)      brk_q <= 1'b1;
            else if (brk_clr) brk_q <= 1'b0;
        end
    end

    // Outputs.
    always_comb begin
        ready    = (state_q != Q_EMPTY);
        full     = (state_q == Q_FULL);
        accept   = rx_en && (state_q != Q_FULL) && !brk_evt;
        brk_flag = brk_q;
    end
endmodule

// File: rtl/rx_hold_queue.sv
module rx_hold_queue #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic              brk_evt,
    input  logic              rd_stb,
    input  logic              rx_reset,
    input  logic              brk_clr,
    output logic              accept,
    output logic [DATA_W-1:0] rd_data,
    output logic              ready,
    output logic              full,
    output logic              brk_flag
);
    logic             shift_en, wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [DATA_W-1:0] wr_data;

    // A break stores a zero byte.
    assign wr_data = brk_evt ? '0 : push_data;

    rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .push_valid(push_valid),
        .brk_evt   (brk_evt),
        .rd_stb    (rd_stb),
        .rx_reset  (rx_reset),
        .brk_clr   (brk_clr),
        .accept    (accept),
        .ready     (ready),
        .full      (full),
        .brk_flag  (brk_flag),
        .shift_en  (shift_en),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx)
    );

    rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(shift_en),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .head    (rd_data)
    );
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en,
    input logic              push_valid,
    input logic [DATA_W-1:0] push_data,
    input logic              brk_evt,
    input logic              rd_stb,
    input logic              rx_reset,
    input logic              brk_clr,
    input logic              accept,
    input logic [DATA_W-1:0] rd_data,
    input logic              ready,
    input logic              full,
    input logic              brk_flag
);
    AST_FULL_IMPLIES_READY: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> ready);                                                                 // R1

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !brk_evt && !rd_stb && !rx_reset)
        |=> ($stable(ready) && $stable(full) && $stable(rd_data)));                     // R3

    AST_BRK_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt |=> brk_flag);                                                           // R4

    AST_BRK_GIVES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_evt && !rx_reset) |=> ready);                                               // R4

    AST_BRK_FULL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && brk_evt && !rd_stb && !rx_reset) |=> full);                            // R5

    AST_READ_FULL_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (full && rd_stb && !brk_evt && !rx_reset) |=> (!full && ready));                // R6

    AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && rd_stb && !push_valid && !brk_evt && !rx_reset)
        |=> ($stable(rd_data) && !ready));                                               // R7

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_reset |=> (!ready && !full));                                                 // R9

    AST_BRK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_clr && !brk_evt) |=> !brk_flag);                                            // R10
endmodule

bind rx_hold_queue rxq_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/rx_hold_queue_bench.sv
module rx_hold_queue_bench;
    localparam int DW = 8;
    localparam int DP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en = 1'b0, push_valid = 1'b0, brk_evt = 1'b0, rd_stb = 1'b0;
    logic rx_reset = 1'b0, brk_clr = 1'b0;
    logic [DW-1:0] push_data = '0;
    logic accept, ready, full, brk_flag;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    logic [DW-1:0] mq [DP];
    int            mcnt = 0;
    logic [DW-1:0] mhead = '0;
    logic          mbrk = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    rx_hold_queue #(.DATA_W(DW), .DEPTH(DP)) u_rx_hold_queue (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .push_valid(push_valid),
        .push_data(push_data), .brk_evt(brk_evt), .rd_stb(rd_stb),
        .rx_reset(rx_reset), .brk_clr(brk_clr), .accept(accept),
        .rd_data(rd_data), .ready(ready), .full(full), .brk_flag(brk_flag)
    );

    task automatic chk(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_head();
        return (mcnt > 0) ? mq[0] : mhead;
    endfunction

    task automatic check_state(input string tag);
        chk(tag == "" ? "R2" : tag, "ready", int'(ready), int'(mcnt > 0));
        chk(tag == "" ? "R1" : tag, "full", int'(full), int'(mcnt == DP));
        chk(tag == "" ? "R4" : tag, "brk_flag", int'(brk_flag), int'(mbrk));
        chk(tag == "" ? "R6" : tag, "rd_data", int'(rd_data), int'(exp_head()));
    endtask

    // One clock cycle of stimulus, model update and checks.
    task automatic step(input string tag, input logic en, input logic pv,
                        input logic [DW-1:0] pd, input logic brk, input logic rd,
                        input logic rxr, input logic clr);
        logic acc;
        @(negedge clk);
        rx_en = en; push_valid = pv; push_data = pd; brk_evt = brk;
        rd_stb = rd; rx_reset = rxr; brk_clr = clr;
        #1;
        acc = en && (mcnt != DP) && !brk;
        chk(tag == "" ? "R3" : tag, "accept", int'(accept), int'(acc));
        @(posedge clk);
        if (rxr) begin
            if (mcnt > 0) mhead = mq[0];
            mcnt = 0;
        end else begin
            if (rd && mcnt > 0) begin
                mhead = mq[0];
                for (int i = 0; i < DP - 1; i++) mq[i] = mq[i+1];
                mcnt--;
            end
            if (brk) begin
                if (mcnt == DP) mq[DP-1] = '0;
                else begin mq[mcnt] = '0; mcnt++; end
            end else if (pv && acc) begin
                mq[mcnt] = pd; mcnt++;
            end
        end
        if (brk) mbrk = 1'b1;
        else if (clr) mbrk = 1'b0;
        #1;
        check_state(tag);
    endtask

    task automatic idle();
        step("", 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic put(input logic [DW-1:0] d);
        step("R2", 1'b1, 1'b1, d, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic get(input string tag);
        step(tag, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                checks++;
                $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        for (int i = 0; i < DP; i++) mq[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        chk("R11", "ready", int'(ready), 0);
        chk("R11", "full", int'(full), 0);
        chk("R11", "brk_flag", int'(brk_flag), 0);
        chk("R11", "rd_data", int'(rd_data), 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle();

        // R1 / R6: fill to capacity, extra push refused, drain in order
        for (int k = 0; k < DP + 1; k++) put(DW'(8'h31 + 8'h07 * k));
        for (int k = 0; k < DP; k++) get("R6");
        // R7: read empty keeps last head
        get("R7");
        get("R7");
        // R3: disabled receiver ignores data
        step("R3", 1'b0, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b0);
        // R4: break while disabled enqueues zero and sets flag
        step("R4", 1'b0, 1'b1, 8'h5A, 1'b1, 1'b0, 1'b0, 1'b0);
        // R10: set wins over clear, then clear
        step("R10", 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1);
        step("R10", 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
        // R5: fill then break overwrites newest
        for (int k = 0; k < DP; k++) put(DW'(8'hC0 + k));
        step("R5", 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
        // R8: read and break on full queue in same cycle
        step("R8", 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0);
        // R9: flush with simultaneous push and read; flag kept
        step("R9", 1'b1, 1'b1, 8'h77, 1'b0, 1'b1, 1'b1, 1'b0);
        // R8: single entry read+push keeps new byte
        put(8'h42);
        step("R8", 1'b1, 1'b1, 8'h43, 1'b0, 1'b1, 1'b0, 1'b0);
        get("R8");

        // Near-exhaustive sweep: every fill level x every input combination
        for (int lvl = 0; lvl <= DP; lvl++) begin
            for (int c = 0; c < 64; c++) begin
                step("R9", 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
                for (int k = 0; k < lvl; k++) put(DW'(lvl * 16 + k * 3 + 1));
                step("R8", c[0], c[1], DW'(c * 5 + 9), c[2], c[3], c[4], c[5]);
                for (int k = 0; k < DP + 1; k++) get("R6");
            end
        end
        idle();
        finish_run();
    end
endmodule